// File: doc/BRIEF.md
# Serial Port Status Flags

This block keeps two status bits for an asynchronous serial port that has a transmit FIFO and a receive FIFO. The receive-error bit records that a character arrived with a bad stop bit or a failed parity check. The transmit-end bit records that the transmitter has run dry. The shifters, the baud timing and the FIFO storage sit outside the block. They report events to it as single-cycle strobes, or as levels for the FIFO-empty state and the transmit enable.

For each completed character, the block also builds the word that goes into the receive FIFO. The word holds the data byte and two per-character marks: one for a framing fault and one for a parity fault. Software can therefore tell which stored byte was damaged. A fault never keeps a character out of the FIFO.

Software reads both flags through a small register port. It clears a flag with a two-step handshake: it must read the flag as 1, and then write 0 to it. Reset and standby put both flags back to their idle values.

Top module: `uart_status_flags`

## Requirements
- R1: When a character completes and its stop-bit sample is 0, the receive-error flag (status bit 1) is 1 from the next cycle, and the pushed word has its framing mark set.
- R2: When parity checking is enabled, the parity mark and the receive-error flag are set if the number of ones in the data plus the parity bit is odd with even parity selected (`par_odd_i`=0), or even with odd parity selected (`par_odd_i`=1).
- R3: When parity checking is disabled, the parity mark stays 0 and no receive error comes from parity, whatever the parity bit is.
- R4: Every character strobe pushes a word one cycle later with the received data, whether or not the character had a fault.
- R5: A status write clears a flag only where the written bit is 0 and that flag was read as 1 after the last status write. Writing 1 has no effect. Any write disarms both flags. A read that returns 0 arms nothing.
- R6: When a set cause and a clear cause hit the same flag in the same cycle, the flag ends up 1.
- R7: Reset and standby make the receive-error flag 0 and the transmit-end flag (status bit 0) 1, and disarm both flags.
- R8: Transmit-end is set when the last bit of a character goes out while the transmit FIFO is empty. If the FIFO still holds data at that point, the flag is unchanged.
- R9: Transmit-end is held at 1 in every cycle where transmission is disabled.
- R10: A write into the transmit FIFO clears transmit-end, unless a set cause is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby_i | input | 1 | Standby level; forces idle flag values |
| rx_done_i | input | 1 | Strobe: a received character is complete |
| rx_data_i | input | 8 | Data of the completed character |
| rx_par_i | input | 1 | Received parity bit |
| rx_stop_i | input | 1 | Sampled (first) stop bit |
| par_en_i | input | 1 | Parity checking enabled |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| rxf_push_o | output | 1 | Push strobe into the receive FIFO |
| rxf_data_o | output | 8 | Data of the pushed word |
| rxf_fer_o | output | 1 | Framing mark of the pushed word |
| rxf_per_o | output | 1 | Parity mark of the pushed word |
| tx_en_i | input | 1 | Transmit enable level |
| tx_last_i | input | 1 | Strobe: last bit of a character shifted out |
| txf_empty_i | input | 1 | Transmit FIFO holds no data |
| txf_wr_i | input | 1 | Strobe: data written into the transmit FIFO |
| reg_rd_i | input | 1 | Status read strobe |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 2 | Write data (bit 1 receive error, bit 0 transmit end) |
| reg_rdata_o | output | 2 | Read data (bit 1 receive error, bit 0 transmit end) |
| rx_err_o | output | 1 | Receive-error flag |
| tx_end_o | output | 1 | Transmit-end flag |

## Verification
Some rules reduce to one cycle of cause and effect, and the assertions check these on every cycle. They cover the idle values after reset and standby, the push that follows each character, the framing mark and the flag it raises, transmit-end being set by an empty FIFO or a disabled transmitter, the clear on a FIFO write, and the rule that the receive-error flag holds until a status write. The read-then-write handshake depends on what happened several cycles earlier. This includes a write with no read before it, a write of 1 that disarms, and a flag raised only after a read that returned 0. Those sequences, and the parity sums under both settings, are shown by the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/ustat_pkg.sv
package ustat_pkg;
    parameter int unsigned RX_DATA_W = 8;
    localparam int unsigned STAT_W    = 2;
    localparam int unsigned IDX_TXEND = 0;
    localparam int unsigned IDX_RXERR = 1;
    localparam logic [STAT_W-1:0] STAT_IDLE = 2'b01;

    typedef logic [RX_DATA_W-1:0] rx_data_t;

    typedef struct packed {
        rx_data_t data;
        logic     fer;
        logic     per;
    } rx_entry_t;

    function automatic logic parity_bad(rx_data_t d, logic pbit, logic odd_sel);
        return (^{d, pbit}) ^ odd_sel;
    endfunction
endpackage

// File: rtl/ustat_rx_check.sv
module ustat_rx_check
    import ustat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done_i,
    input  rx_data_t  data_i,
    input  logic      par_i,
    input  logic      stop_i,
    input  logic      par_en_i,
    input  logic      par_odd_i,
    output logic      err_set_o,
    output logic      push_o,
    output rx_entry_t entry_o
);
    rx_entry_t chk;

    always_comb begin
        chk.data  = data_i;
        chk.fer   = ~stop_i;
        chk.per   = par_en_i & parity_bad(data_i, par_i, par_odd_i);
        err_set_o = done_i & (chk.fer | chk.per);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_o  <= 1'b0;
            entry_o <= '0;
        end else begin
            push_o <= done_i;
            if (done_i) entry_o <= chk;
        end
    end
endmodule

// File: rtl/ustat_flag_cell.sv
module ustat_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic force_i,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr_req;

    always_comb begin
        clr_req = hw_clr_i | (wr_i & ~wbit_i & armed_q);
        flag_o  = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst || force_i) begin
            flag_q  <= RST_VAL;
            armed_q <= 1'b0;
        end else begin
            if (set_i)        flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;

            if (wr_i)                     armed_q <= 1'b0;
            else if (hw_clr_i && !set_i)  armed_q <= 1'b0;
            else if (rd_i && flag_q)      armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
    import ustat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 standby_i,
    input  logic                 rx_done_i,
    input  logic [RX_DATA_W-1:0] rx_data_i,
    input  logic                 rx_par_i,
    input  logic                 rx_stop_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    output logic                 rxf_push_o,
    output logic [RX_DATA_W-1:0] rxf_data_o,
    output logic                 rxf_fer_o,
    output logic                 rxf_per_o,
    input  logic                 tx_en_i,
    input  logic                 tx_last_i,
    input  logic                 txf_empty_i,
    input  logic                 txf_wr_i,
    input  logic                 reg_rd_i,
    input  logic                 reg_wr_i,
    input  logic [STAT_W-1:0]    reg_wdata_i,
    output logic [STAT_W-1:0]    reg_rdata_o,
    output logic                 rx_err_o,
    output logic                 tx_end_o
);
    logic        rx_err_set;
    rx_entry_t   entry;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] hwclr_v;
    logic [STAT_W-1:0] flags;

    ustat_rx_check u_rx_check (
        .clk       (clk),
        .rst       (rst),
        .done_i    (rx_done_i),
        .data_i    (rx_data_i),
        .par_i     (rx_par_i),
        .stop_i    (rx_stop_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .err_set_o (rx_err_set),
        .push_o    (rxf_push_o),
        .entry_o   (entry)
    );

    always_comb begin
        set_v              = '0;
        hwclr_v            = '0;
        set_v[IDX_TXEND]   = ~tx_en_i | (tx_last_i & txf_empty_i);
        hwclr_v[IDX_TXEND] = txf_wr_i;
        set_v[IDX_RXERR]   = rx_err_set;
    end

    for (genvar gi = 0; gi < STAT_W; gi++) begin : g_flag
        ustat_flag_cell #(.RST_VAL(STAT_IDLE[gi])) u_cell (
            .clk      (clk),
            .rst      (rst),
            .force_i  (standby_i),
            .set_i    (set_v[gi]),
            .hw_clr_i (hwclr_v[gi]),
            .rd_i     (reg_rd_i),
            .wr_i     (reg_wr_i),
            .wbit_i   (reg_wdata_i[gi]),
            .flag_o   (flags[gi])
        );
    end

    always_comb begin
        reg_rdata_o = flags;
        rx_err_o    = flags[IDX_RXERR];
        tx_end_o    = flags[IDX_TXEND];
        rxf_data_o  = entry.data;
        rxf_fer_o   = entry.fer;
        rxf_per_o   = entry.per;
    end
endmodule

// File: rtl/uart_status_flags_chk.sv
module uart_status_flags_chk
    import ustat_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 standby_i,
    input logic                 rx_done_i,
    input logic [RX_DATA_W-1:0] rx_data_i,
    input logic                 rx_stop_i,
    input logic                 rxf_push_o,
    input logic [RX_DATA_W-1:0] rxf_data_o,
    input logic                 rxf_fer_o,
    input logic                 tx_en_i,
    input logic                 tx_last_i,
    input logic                 txf_empty_i,
    input logic                 txf_wr_i,
    input logic                 reg_wr_i,
    input logic                 rx_err_o,
    input logic                 tx_end_o
);
    p_idle_after_reset_r7: assert property (@(posedge clk)
        (rst || standby_i) |=> (tx_end_o && !rx_err_o));

    p_push_follows_char_r4: assert property (@(posedge clk) disable iff (rst)
        rx_done_i |=> (rxf_push_o && rxf_data_o == $past(rx_data_i)));

    p_frame_mark_r1: assert property (@(posedge clk) disable iff (rst)
        rx_done_i |=> (rxf_fer_o == !$past(rx_stop_i)));

    p_frame_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_done_i && !rx_stop_i && !standby_i) |=> rx_err_o);

    p_empty_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_last_i && txf_empty_i) |=> tx_end_o);

    p_disabled_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_en_i |=> tx_end_o);

    p_fifo_write_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (txf_wr_i && tx_en_i && !(tx_last_i && txf_empty_i) && !standby_i) |=> !tx_end_o);

    p_err_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_err_o && !reg_wr_i && !standby_i) |=> rx_err_o);
endmodule

bind uart_status_flags uart_status_flags_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .standby_i   (standby_i),
    .rx_done_i   (rx_done_i),
    .rx_data_i   (rx_data_i),
    .rx_stop_i   (rx_stop_i),
    .rxf_push_o  (rxf_push_o),
    .rxf_data_o  (rxf_data_o),
    .rxf_fer_o   (rxf_fer_o),
    .tx_en_i     (tx_en_i),
    .tx_last_i   (tx_last_i),
    .txf_empty_i (txf_empty_i),
    .txf_wr_i    (txf_wr_i),
    .reg_wr_i    (reg_wr_i),
    .rx_err_o    (rx_err_o),
    .tx_end_o    (tx_end_o)
);

// File: tb/uart_status_flags_bench.sv
module uart_status_flags_bench;
    import ustat_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_i = 1'b0;
    logic rx_done_i = 1'b0;
    logic [RX_DATA_W-1:0] rx_data_i = '0;
    logic rx_par_i = 1'b0;
    logic rx_stop_i = 1'b1;
    logic par_en_i = 1'b0;
    logic par_odd_i = 1'b0;
    logic tx_en_i = 1'b1;
    logic tx_last_i = 1'b0;
    logic txf_empty_i = 1'b1;
    logic txf_wr_i = 1'b0;
    logic reg_rd_i = 1'b0;
    logic reg_wr_i = 1'b0;
    logic [1:0] reg_wdata_i = 2'b11;
    logic rxf_push_o;
    logic [RX_DATA_W-1:0] rxf_data_o;
    logic rxf_fer_o, rxf_per_o;
    logic [1:0] reg_rdata_o;
    logic rx_err_o, tx_end_o;

    int checks = 0;
    int errs = 0;
    string cur_req = "R7";
    bit started = 0;

    // reference model state
    bit m_rxe = 0, m_txe = 1, m_ar = 0, m_at = 0, m_push = 0;
    bit [RX_DATA_W-1:0] m_data = '0;
    bit m_fer = 0, m_per = 0;

    always #5 clk = ~clk;

    uart_status_flags u_uart_status_flags (
        .clk(clk), .rst(rst), .standby_i(standby_i),
        .rx_done_i(rx_done_i), .rx_data_i(rx_data_i), .rx_par_i(rx_par_i),
        .rx_stop_i(rx_stop_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
        .rxf_push_o(rxf_push_o), .rxf_data_o(rxf_data_o),
        .rxf_fer_o(rxf_fer_o), .rxf_per_o(rxf_per_o),
        .tx_en_i(tx_en_i), .tx_last_i(tx_last_i), .txf_empty_i(txf_empty_i),
        .txf_wr_i(txf_wr_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .rx_err_o(rx_err_o), .tx_end_o(tx_end_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_rxe = 0; m_txe = 1; m_ar = 0; m_at = 0; m_push = 0;
            m_data = '0; m_fer = 0; m_per = 0;
            started = 1;
        end else begin
            int ones;
            bit e_fer, e_per, set_r, clr_r, set_t, clr_t, n_r, n_t;
            ones = rx_par_i ? 1 : 0;
            for (int k = 0; k < RX_DATA_W; k++) if (rx_data_i[k]) ones++;
            e_fer = !rx_stop_i;
            e_per = par_en_i && (((ones % 2) == 1) != par_odd_i);
            m_push = rx_done_i;
            if (rx_done_i) begin
                m_data = rx_data_i; m_fer = e_fer; m_per = e_per;
            end
            if (standby_i) begin
                m_rxe = 0; m_txe = 1; m_ar = 0; m_at = 0;
            end else begin
                set_r = rx_done_i && (e_fer || e_per);
                clr_r = reg_wr_i && !reg_wdata_i[1] && m_ar;
                set_t = !tx_en_i || (tx_last_i && txf_empty_i);
                clr_t = txf_wr_i || (reg_wr_i && !reg_wdata_i[0] && m_at);
                n_r = set_r ? 1 : (clr_r ? 0 : m_rxe);
                n_t = set_t ? 1 : (clr_t ? 0 : m_txe);
                m_ar = !reg_wr_i && n_r && (m_ar || (reg_rd_i && m_rxe));
                m_at = !reg_wr_i && n_t && (m_at || (reg_rd_i && m_txe));
                m_rxe = n_r; m_txe = n_t;
            end
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "rx_err vs model", rx_err_o, m_rxe);
            chk(cur_req, "tx_end vs model", tx_end_o, m_txe);
            chk(cur_req, "rdata vs model", reg_rdata_o, {m_rxe, m_txe});
            chk(cur_req, "push vs model", rxf_push_o, m_push);
            if (m_push) begin
                chk(cur_req, "data vs model", rxf_data_o, m_data);
                chk(cur_req, "fer vs model", rxf_fer_o, m_fer);
                chk(cur_req, "per vs model", rxf_per_o, m_per);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        rx_done_i = 0; tx_last_i = 0; txf_wr_i = 0;
        reg_rd_i = 0; reg_wr_i = 0; reg_wdata_i = 2'b11;
    endtask

    task automatic send_char(input logic [RX_DATA_W-1:0] d, input logic p, input logic s);
        rx_data_i = d; rx_par_i = p; rx_stop_i = s; rx_done_i = 1;
        tick();
    endtask

    task automatic read_stat();
        reg_rd_i = 1; tick();
    endtask

    task automatic write_stat(input logic [1:0] v);
        reg_wr_i = 1; reg_wdata_i = v; tick();
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog all-requirements: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (2) tick();
        rst = 0;
        tick();
        cur_req = "R7";
        chk("R7", "reset rx_err", rx_err_o, 0);
        chk("R7", "reset tx_end", tx_end_o, 1);
        chk("R7", "reset rdata", reg_rdata_o, 2'b01);

        // transmit-end
        cur_req = "R10";
        txf_empty_i = 0; txf_wr_i = 1; tick();
        chk("R10", "fifo write clears tx_end", tx_end_o, 0);
        cur_req = "R8";
        tx_last_i = 1; tick();
        chk("R8", "last bit with data left", tx_end_o, 0);
        txf_empty_i = 1; tx_last_i = 1; tick();
        chk("R8", "last bit with empty fifo", tx_end_o, 1);
        cur_req = "R9";
        txf_empty_i = 0; txf_wr_i = 1; tick();
        tx_en_i = 0; tick();
        chk("R9", "disabled sets tx_end", tx_end_o, 1);
        cur_req = "R6";
        txf_wr_i = 1; tick();
        chk("R6", "fifo write while disabled", tx_end_o, 1);
        tx_en_i = 1; txf_empty_i = 1; tick();

        // receive path
        cur_req = "R4";
        send_char(8'hA5, 0, 1);
        chk("R4", "clean char pushed", rxf_push_o, 1);
        chk("R4", "clean char data", rxf_data_o, 8'hA5);
        chk("R4", "clean char no error", rx_err_o, 0);
        cur_req = "R1";
        send_char(8'h3C, 0, 0);
        chk("R1", "framing sets flag", rx_err_o, 1);
        chk("R1", "framing mark", rxf_fer_o, 1);
        chk("R4", "faulty char still pushed", rxf_push_o, 1);

        // clearing handshake
        cur_req = "R5";
        write_stat(2'b01);
        chk("R5", "write 0 without read", rx_err_o, 1);
        read_stat();
        write_stat(2'b11);
        chk("R5", "write 1 has no effect", rx_err_o, 1);
        write_stat(2'b01);
        chk("R5", "write after disarm", rx_err_o, 1);
        read_stat();
        write_stat(2'b01);
        chk("R5", "read 1 then write 0 clears", rx_err_o, 0);
        read_stat();
        send_char(8'h00, 0, 0);
        write_stat(2'b01);
        chk("R5", "read 0 arms nothing", rx_err_o, 1);

        cur_req = "R6";
        read_stat();
        reg_wr_i = 1; reg_wdata_i = 2'b01;
        rx_data_i = 8'h11; rx_par_i = 0; rx_stop_i = 0; rx_done_i = 1;
        tick();
        chk("R6", "set beats clear", rx_err_o, 1);

        // parity
        cur_req = "R7";
        standby_i = 1; tick(); standby_i = 0; tick();
        chk("R7", "standby clears rx_err", rx_err_o, 0);
        cur_req = "R2";
        par_en_i = 1; par_odd_i = 0;
        send_char(8'h03, 1, 1);
        chk("R2", "even parity mismatch mark", rxf_per_o, 1);
        chk("R2", "even parity mismatch flag", rx_err_o, 1);
        standby_i = 1; tick(); standby_i = 0;
        par_odd_i = 1;
        send_char(8'h03, 1, 1);
        chk("R2", "odd parity match", rxf_per_o, 0);
        chk("R2", "odd parity no flag", rx_err_o, 0);
        send_char(8'h07, 1, 1);
        chk("R2", "odd parity mismatch", rxf_per_o, 1);
        standby_i = 1; tick(); standby_i = 0;
        cur_req = "R3";
        par_en_i = 0;
        send_char(8'h01, 0, 1);
        chk("R3", "parity off mark", rxf_per_o, 0);
        chk("R3", "parity off flag", rx_err_o, 0);

        // standby with activity
        cur_req = "R7";
        txf_empty_i = 0; txf_wr_i = 1; tick();
        send_char(8'h55, 0, 0);
        standby_i = 1;
        send_char(8'h66, 0, 0);
        chk("R7", "standby rx_err", rx_err_o, 0);
        chk("R7", "standby tx_end", tx_end_o, 1);
        chk("R4", "push during standby", rxf_push_o, 1);
        standby_i = 0; txf_empty_i = 1;
        tick();
        rst = 1; tick(); rst = 0; tick();
        chk("R7", "second reset rdata", reg_rdata_o, 2'b01);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule